// File: doc/BRIEF.md
# Pipelined Separable 2-D Wavelet Filter

This block runs a two-stage separable filter over a streamed image, as used in one level of a 2-D wavelet transform. Pixels arrive as words of four vertically adjacent pixels. A row strip four pixels high is swept column by column, and strips follow each other from top to bottom. The first stage filters each column of the strip along the vertical axis with four programmable taps. The second stage filters those intermediate columns along the horizontal axis with four more taps. Intermediate data never leaves the block, so every pixel is read once.

Stage one produces one intermediate column per accepted word. Stage two consumes that column at once, together with a short history of earlier columns. Both stages therefore run in the same cycle, and the block delivers four doubly filtered pixels per clock once two columns have been buffered. Image borders are handled inside the block by symmetric mirroring. A three-pixel line store carries the bottom of each strip over to the next strip. A five-column history covers the horizontal window.

Top module: `wavelet2d_pipe`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. All eight coefficients are zero, so a frame run without coefficient writes yields all-zero outputs.
- R2: Bits 8i+7..8i of in_data hold the unsigned pixel of row 4s+i and column c. Words arrive with c running 0..W-1 inside strip s, and s running 0..H/4-1.
- R3: Stage one computes T[r][c] = A0·X[r][c] + A1·X[r-1][c] + A2·X[r-2][c] + A3·X[r-3][c]. A row index -j (j = 1..3) reads row j-1.
- R4: Stage two computes Y[r][c] = B0·T[r][c] + B1·T[r][c-1] + B2·T[r][c-2] + B3·T[r][c-3]. A column index -j reads column j-1. Lane i (bits 16i+15..16i) of out_data carries floor((Y + 2^27) / 2^28) as a 16-bit signed value for row 4s+i. Output groups follow the input word order.
- R5: With out_ready held at 1, the first output group is valid in the cycle after the third input word of a frame is accepted.
- R6: With continuous input and out_ready at 1, one word is accepted per cycle. in_ready is 0 for exactly the two cycles after the last word of a frame is accepted. The last output group becomes valid three cycles after that word is accepted.
- R7: out_sof is 1 only on the first group of a frame. out_eol is 1 on the group of column W-1 of every strip.
- R8: While out_valid is 1 and out_ready is 0, out_data and the flags hold and in_ready is 0. No group is lost or repeated under any pattern of stalls.
- R9: coef_sel 0..3 selects A0..A3 and 4..7 selects B0..B3, as signed values with 14 fractional bits. A write takes effect only when no frame is in progress. A write made during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient index (0..3 stage one, 4..7 stage two) |
| coef_data | input | CW | Signed coefficient value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Four vertically adjacent pixels |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream can take the group |
| out_data | output | 64 | Four filtered pixels, 16-bit signed each |
| out_sof | output | 1 | First group of the frame |
| out_eol | output | 1 | Last group of a strip row |

## Verification
A word accepted at one clock edge has its intermediate column written into the history at that edge. The group for two columns earlier is also registered at that edge, so a group is due one cycle after the acceptance that completes its window. The two drain groups at the end of a frame follow at one per cycle. The bench drives inputs at the falling edge and reads the handshakes a moment later. It logs the cycle of each acceptance and of each group's first appearance, so the R5 and R6 windows are checked as exact cycle differences rather than by polling. Stall checks compare each held group with its value from the cycle before. Data checks compare the groups in arrival order against a frame computed in the bench from R3 and R4.

// File: rtl/wavelet2d_pipe.sv
module wavelet2d_pipe #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int CW    = 16,
  parameter int FRAC  = 14
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_we,
  input  logic [2:0]    coef_sel,
  input  logic [CW-1:0] coef_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data,
  output logic          out_sof,
  output logic          out_eol
);
  localparam int NSTR = IMG_H / 4;
  localparam int XW   = $clog2(IMG_W);
  localparam int SW   = (NSTR > 1) ? $clog2(NSTR) : 1;
  localparam int TW   = CW + 11;
  localparam int YW   = TW + CW + 2;
  localparam int SH   = 2 * FRAC;
  localparam logic [XW-1:0] LASTC = XW'(IMG_W - 1);
  localparam logic [SW-1:0] LASTS = SW'(NSTR - 1);
  localparam logic signed [YW-1:0] RND = YW'(64'd1 << (SH - 1));

  logic signed [CW-1:0] ca [4];
  logic signed [CW-1:0] cb [4];
  logic signed [TW-1:0] cax [4];
  logic signed [YW-1:0] cbx [4];
  logic [23:0] lb [IMG_W];
  logic [23:0] lbw;
  logic signed [TW-1:0] hist [5][4];
  logic signed [TW-1:0] nh [6][4];
  logic signed [TW-1:0] tv [4];
  logic [7:0] ev [7];
  logic signed [YW-1:0] yacc [4];
  logic [15:0] yq [4];
  int jx [4];
  int oc, d, q;

  logic busy;
  logic [1:0] fill, drain;
  logic [XW-1:0] icol, ocol;
  logic [SW-1:0] istr, ostr;

  logic adv, acc, bub, step, emit, last_in;
  assign adv     = out_ready | ~out_valid;
  assign in_ready = adv & (drain == 2'd0);
  assign acc     = in_valid & in_ready;
  assign bub     = adv & (drain != 2'd0);
  assign step    = acc | bub;
  assign emit    = step & (fill == 2'd2);
  assign last_in = acc & (icol == LASTC) & (istr == LASTS);
  assign lbw     = lb[icol];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      cax[k] = $signed({{(TW-CW){ca[k][CW-1]}}, ca[k]});
      cbx[k] = $signed({{(YW-CW){cb[k][CW-1]}}, cb[k]});
    end
    for (int i = 0; i < 4; i++) ev[3+i] = in_data[8*i +: 8];
    if (istr == '0) begin
      ev[2] = in_data[7:0];  ev[1] = in_data[15:8]; ev[0] = in_data[23:16];
    end else begin
      ev[2] = lbw[23:16];    ev[1] = lbw[15:8];     ev[0] = lbw[7:0];
    end
    for (int i = 0; i < 4; i++) begin
      tv[i] = '0;
      for (int k = 0; k < 4; k++)
        tv[i] = tv[i] + cax[k] * $signed({{(TW-8){1'b0}}, ev[3+i-k]});
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) nh[0][i] = tv[i];
    for (int j = 1; j < 6; j++)
      for (int i = 0; i < 4; i++) nh[j][i] = hist[j-1][i];
    oc = (int'(ocol) > 3) ? 3 : int'(ocol);
    d = 0;
    q = 0;
    for (int k = 0; k < 4; k++) begin
      d = oc - k;
      q = (d < 0) ? -d - 1 : d;
      jx[k] = 2 + oc - q;
    end
    for (int i = 0; i < 4; i++) begin
      yacc[i] = '0;
      for (int k = 0; k < 4; k++)
        yacc[i] = yacc[i] + cbx[k] * $signed({{(YW-TW){nh[jx[k]][i][TW-1]}}, nh[jx[k]][i]});
      yq[i] = 16'((yacc[i] + RND) >>> SH);
    end
  end

  always_ff @(posedge clk) begin
    if (acc) lb[icol] <= in_data[31:8];
    if (step)
      for (int i = 0; i < 4; i++) begin
        hist[0][i] <= tv[i];
        for (int j = 1; j < 5; j++) hist[j][i] <= hist[j-1][i];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        ca[k] <= '0;
        cb[k] <= '0;
      end
      busy <= 1'b0;  fill <= '0;  drain <= '0;
      icol <= '0;    istr <= '0;  ocol <= '0;  ostr <= '0;
      out_valid <= 1'b0;  out_data <= '0;  out_sof <= 1'b0;  out_eol <= 1'b0;
    end else begin
      if (coef_we && !busy && !acc) begin
        if (coef_sel[2]) cb[coef_sel[1:0]] <= coef_data;
        else             ca[coef_sel[1:0]] <= coef_data;
      end
      if (acc) begin
        busy <= 1'b1;
        if (icol == LASTC) begin
          icol <= '0;
          istr <= (istr == LASTS) ? '0 : istr + 1'b1;
        end else icol <= icol + 1'b1;
        if (last_in) drain <= 2'd2;
      end
      if (step && fill != 2'd2) fill <= fill + 1'b1;
      if (bub) begin
        drain <= drain - 1'b1;
        if (drain == 2'd1) begin
          busy <= 1'b0;
          fill <= '0;
        end
      end
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= {yq[3], yq[2], yq[1], yq[0]};
        out_sof   <= (ocol == '0) && (ostr == '0);
        out_eol   <= (ocol == LASTC);
        if (ocol == LASTC) begin
          ocol <= '0;
          ostr <= (ostr == LASTS) ? '0 : ostr + 1'b1;
        end else ocol <= ocol + 1'b1;
      end else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

module wavelet2d_pipe_chk #(
  parameter int CW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_sof,
  input logic          out_eol,
  input logic          busy,
  input logic [63:0]   out_data,
  input logic [8*CW-1:0] coefs
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));
  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R7
  sof_eol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !out_eol);
  // R5
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
  // R9
  coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(coefs));
endmodule

bind wavelet2d_pipe wavelet2d_pipe_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sof(out_sof), .out_eol(out_eol), .busy(busy),
  .out_data(out_data),
  .coefs({ca[0], ca[1], ca[2], ca[3], cb[0], cb[1], cb[2], cb[3]})
);

// File: tb/tb_wavelet2d_pipe.sv
module tb_wavelet2d_pipe;
  localparam int IW = 8;
  localparam int IH = 8;
  localparam int NW = IW * IH / 4;
  // a0..a3, b0..b3, pattern, flow mode
  localparam int CTAB [4][10] = '{
    '{16384, 0, 0, 0, 16384, 0, 0, 0, 0, 0},
    '{4096, 4096, 4096, 4096, 4096, 4096, 4096, 4096, 1, 0},
    '{-8192, 16384, -8192, 2048, 16384, -16384, 3000, -5, 3, 1},
    '{32767, -32768, 32767, -32768, -32768, 32767, -32768, 32767, 2, 2}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, coef_we, in_valid, in_ready, out_valid, out_ready, out_sof, out_eol;
  logic [2:0] coef_sel;
  logic [15:0] coef_data;
  logic [31:0] in_data;
  logic [63:0] out_data;

  wavelet2d_pipe #(.IMG_W(IW), .IMG_H(IH)) dut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_data(coef_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
  );

  int total = 0, bad = 0;
  int pix [IH][IW];
  longint expv [NW][4];
  int ca_m [4], cb_m [4];
  int g_idx, g_sel, g_val;
  int t_first_acc, t_acc2, t_last_acc, t_first_out, t_last_out;
  logic ir_after [3];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expd);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expd);
    end
  endtask

  function automatic int mir(input int i);
    return (i < 0) ? -i - 1 : i;
  endfunction

  function automatic int pixel_of(input int pat, input int r, input int c);
    case (pat)
      0: return (r * 32 + c * 3) & 255;
      1: return ((r * 97 + c * 57 + r * c * 13) ^ (c << 3)) & 255;
      2: return ((r + c) % 2 == 1) ? 255 : 0;
      default: return (r * r * 7 + c * 31 + 11) & 255;
    endcase
  endfunction

  task automatic build(input int pat);
    for (int r = 0; r < IH; r++)
      for (int c = 0; c < IW; c++) pix[r][c] = pixel_of(pat, r, c);
    for (int s = 0; s < IH / 4; s++)
      for (int c = 0; c < IW; c++)
        for (int i = 0; i < 4; i++) begin
          longint y = 0;
          for (int k2 = 0; k2 < 4; k2++) begin
            longint t = 0;
            for (int k1 = 0; k1 < 4; k1++)
              t += longint'(ca_m[k1]) * pix[mir(4*s+i-k1)][mir(c-k2)];
            y += longint'(cb_m[k2]) * t;
          end
          expv[s*IW+c][i] = (y + (64'sd1 <<< 27)) >>> 28;
        end
  endtask

  function automatic logic [31:0] word_of(input int idx);
    int s = idx / IW, c = idx % IW;
    return {8'(pix[4*s+3][c]), 8'(pix[4*s+2][c]), 8'(pix[4*s+1][c]), 8'(pix[4*s][c])};
  endfunction

  task automatic write_coef(input int sel, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 3'(sel); coef_data = 16'(val);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic load_coefs(input int v);
    for (int k = 0; k < 4; k++) begin
      write_coef(k, CTAB[v][k]);       ca_m[k] = CTAB[v][k];
      write_coef(k + 4, CTAB[v][k+4]); cb_m[k] = CTAB[v][k+4];
    end
  endtask

  task automatic run_frame(input int mode);
    int idx = 0, k = 0, it = 0;
    bit hold = 0, a, f, sofh, eolh;
    logic [63:0] held;
    t_first_acc = -1; t_acc2 = -1; t_last_acc = -1; t_first_out = -1; t_last_out = -1;
    while (k < NW) begin
      @(negedge clk);
      it++;
      in_valid  = (idx < NW) && !(mode == 1 && it % 5 == 2);
      in_data   = (idx < NW) ? word_of(idx) : 32'h0;
      out_ready = !(mode == 1 && it % 3 == 1) && !(mode == 2 && it % 4 != 0);
      coef_we   = (idx == g_idx) && in_valid;
      coef_sel  = 3'(g_sel);
      coef_data = 16'(g_val);
      #1;
      if (hold) begin
        // R8: a stalled group must be unchanged one cycle later
        check(out_valid && out_data == held && out_sof == sofh && out_eol == eolh,
              "R8", "held group changed", longint'(out_data[31:0]), longint'(held[31:0]));
      end
      hold = out_valid && !out_ready;
      held = out_data; sofh = out_sof; eolh = out_eol;
      if (t_last_acc >= 0 && it > t_last_acc && it <= t_last_acc + 3)
        ir_after[it - t_last_acc - 1] = in_ready;
      a = in_valid && in_ready;
      f = out_valid && out_ready;
      if (out_valid && t_first_out < 0) t_first_out = it;
      if (f) begin
        bit ok = 1;
        longint act = 0, expd = 0;
        for (int i = 0; i < 4; i++)
          if (longint'($signed(out_data[16*i +: 16])) != expv[k][i] && ok) begin
            ok = 0; act = longint'($signed(out_data[16*i +: 16])); expd = expv[k][i];
          end
        // R2 R3 R4: filtered data in order
        check(ok, "R2 R3 R4", $sformatf("group %0d", k), act, expd);
        // R7: frame and row flags
        check(out_sof == (k == 0) && out_eol == (k % IW == IW - 1), "R7",
              $sformatf("flags group %0d", k), {out_sof, out_eol},
              {k == 0, k % IW == IW - 1});
        if (k == NW - 1) t_last_out = it;
        k++;
      end
      if (a) begin
        if (idx == 0) t_first_acc = it;
        if (idx == 2) t_acc2 = it;
        if (idx == NW - 1) t_last_acc = it;
        idx++;
      end
      if (it > 4000) begin
        check(0, "R6", "frame did not complete", k, NW);
        break;
      end
    end
    coef_we = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; coef_we = 1'b0; coef_sel = '0; coef_data = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0; g_idx = -1; g_sel = 0; g_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R1: reset coefficients are zero, every output must be zero
    for (int k = 0; k < 4; k++) begin ca_m[k] = 0; cb_m[k] = 0; end
    build(1);
    run_frame(0);

    for (int v = 0; v < 4; v++) begin
      load_coefs(v);
      build(CTAB[v][8]);
      run_frame(CTAB[v][9]);
    end

    // R5 R6: latency, throughput and drain with full flow
    load_coefs(2);
    build(3);
    run_frame(0);
    check(t_first_out == t_acc2 + 1, "R5", "first group cycle", t_first_out, t_acc2 + 1);
    check(t_last_acc - t_first_acc == NW - 1, "R6", "accept span",
          t_last_acc - t_first_acc, NW - 1);
    check(t_last_out == t_last_acc + 3, "R6", "last group cycle", t_last_out, t_last_acc + 3);
    check(ir_after[0] == 1'b0 && ir_after[1] == 1'b0, "R6", "in_ready during drain",
          {ir_after[0], ir_after[1]}, 0);
    check(ir_after[2] == 1'b1, "R6", "in_ready after drain", ir_after[2], 1);

    // R9: writes during a frame must be ignored, for both stages
    load_coefs(0);
    build(3);
    g_idx = 5; g_sel = 4; g_val = 1234;
    run_frame(0);
    g_idx = 9; g_sel = 1; g_val = -7000;
    run_frame(1);
    g_idx = -1;
    run_frame(0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule